// File: doc/BRIEF.md
# Serially Seeded Long Pseudo-Random Bit Generator

This block produces one pseudo-random bit per enabled clock from a 129-stage shift register with maximal-length linear feedback. Only the last stage drives the output. Every other stage holds a delayed copy of that same stream, so bringing them out would add no new randomness.

A seed can be shifted into the register one bit per clock through a single-bit input. This lets each power-up begin at a different point of the sequence without adding any storage. A debug input forces a fixed, known state so that runs can be repeated. Reset loads the same known state, so an unseeded generator always repeats the same sequence.

If the register ever holds all zeros, it would never leave that state. The block detects this, reloads the known state, and raises a one-cycle flag.

Top module: `prbs_serial_lfsr`

## Requirements
- R1: On reset (`rst_n` low), the register loads the debug state. That state is 129 bits, hex 1_DEADBEEF_01234567_89ABCDEF_5A5AA5A5, with stage k held in bit k-1. After reset `rnd_bit` is 1 (the bit of stage 129) and `lockup` is 0.
- R2: When `enable` is high and no higher-priority action applies, each clock moves stage k into stage k+1. Stage 1 receives the XOR of stage 129 and stage 124, which gives the feedback x^129 + x^5 + 1.
- R3: When `enable` is low and no other action applies, the register holds and `rnd_bit` does not change.
- R4: While `seed_load` is high, `seed_bit` enters stage 1 in place of the feedback and the other stages shift as usual. This happens whatever the level of `enable`, so the output keeps running. After 129 seed clocks followed by stepping, `rnd_bit` repeats the seed bits in the order they were loaded.
- R5: `force_dbg` loads the debug state on the next clock. It takes priority over `seed_load`, over `enable` and over zero recovery.
- R6: `seed_load` takes priority over normal stepping. When both it and `enable` are high, the feedback value is discarded.
- R7: If the register is all zeros and neither `force_dbg` nor `seed_load` is high, the next clock loads the debug state and `lockup` is 1 for exactly that cycle. This happens even when `enable` is low.
- R8: After reset, or after a forced load, the output stream is the same bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Advance the generator one step |
| seed_load | input | 1 | Shift `seed_bit` into stage 1 |
| seed_bit | input | 1 | Serial seed data |
| force_dbg | input | 1 | Load the fixed debug state |
| rnd_bit | output | 1 | Pseudo-random output (stage 129) |
| lockup | output | 1 | One-cycle flag: an all-zero state was replaced |

## Verification
The output stream is compared on every cycle against a bench model of the register, under several kinds of stimulus:
- Long runs with `enable` always high check the tap positions (R2).
- Runs with `enable` toggling separate holding from stepping (R3).
- Random seeds of the full register length, replayed through the output, confirm both the serial entry path and the order in which seed bits leave (R4).
- Overlapping control inputs expose any error in priority (R5, R6).
- An all-zero seed, released with `enable` low and with `enable` high, checks recovery and the flag (R7).
- A random mix of all inputs then covers interactions that the directed cases miss.

// File: rtl/prbs_pkg.sv
// Package: shared action encoding for the serial-seeded PRBS generator.
// Assumes: one action is chosen per clock by the priority decoder.
package prbs_pkg;
    typedef enum logic [2:0] {
        ACT_HOLD    = 3'd0,
        ACT_STEP    = 3'd1,
        ACT_SEED    = 3'd2,
        ACT_RECOVER = 3'd3,
        ACT_FORCE   = 3'd4
    } prbs_act_e;
endpackage

// File: rtl/prbs_priority.sv
// Module: picks the single register action for this clock.
// Priority order: force > seed > zero recovery > step > hold.
// Assumes: state_zero is only meaningful when no seed or force is pending.
module prbs_priority
    import prbs_pkg::*;
(
    input  logic      force_dbg,
    input  logic      seed_load,
    input  logic      enable,
    input  logic      state_zero,
    output prbs_act_e act
);
    // Priority decode of the control inputs.
    always_comb begin
        if (force_dbg)       act = ACT_FORCE;
        else if (seed_load)  act = ACT_SEED;
        else if (state_zero) act = ACT_RECOVER;
        else if (enable)     act = ACT_STEP;
        else                 act = ACT_HOLD;
    end
endmodule

// File: rtl/prbs_feedback.sv
// Module: two-tap XOR feedback for a Fibonacci shift register.
// Assumes: stages are numbered 1..WIDTH, stage k held in bit k-1, and
// 1 <= TAP_LO < TAP_HI <= WIDTH.
module prbs_feedback #(
    parameter int WIDTH  = 129,
    parameter int TAP_HI = 129,
    parameter int TAP_LO = 124
) (
    input  logic [WIDTH-1:0] state,
    output logic             fb
);
    localparam int HI_IDX = TAP_HI - 1;
    localparam int LO_IDX = TAP_LO - 1;

    // XOR of the two tapped stages.
    always_comb fb = state[HI_IDX] ^ state[LO_IDX];
endmodule

// File: rtl/prbs_zero_detect.sv
// Module: flags an all-zero register using a chunked OR tree.
// Assumes: CHUNK >= 1; the register is zero-extended to a multiple of CHUNK.
module prbs_zero_detect #(
    parameter int WIDTH = 129,
    parameter int CHUNK = 16
) (
    input  logic [WIDTH-1:0] state,
    output logic             is_zero
);
    localparam int NCHUNK = (WIDTH + CHUNK - 1) / CHUNK;
    localparam int PADW   = NCHUNK * CHUNK;

    logic [PADW-1:0]   padded;
    logic [NCHUNK-1:0] chunk_any;

    // Zero-extend the register to whole chunks.
    always_comb padded = PADW'(state);

    for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
        // First level: any bit set within this chunk.
        always_comb chunk_any[g] = |padded[g*CHUNK +: CHUNK];
    end

    // Second level: no chunk has a set bit.
    always_comb is_zero = ~|chunk_any;
endmodule

// File: rtl/prbs_serial_lfsr.sv
// Module: 129-stage maximal-length PRBS generator with serial seeding,
// a forced debug state and all-zero recovery. One output bit per step,
// taken from the last stage.
// Assumes: synchronous active-low reset; control inputs are synchronous to clk.
module prbs_serial_lfsr
    import prbs_pkg::*;
#(
    parameter int               WIDTH     = 129,
    parameter int               TAP_HI    = 129,
    parameter int               TAP_LO    = 124,
    parameter int               ZERO_CHNK = 16,
    parameter logic [WIDTH-1:0] DBG_STATE = 129'h1_DEADBEEF_01234567_89ABCDEF_5A5AA5A5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic seed_load,
    input  logic seed_bit,
    input  logic force_dbg,
    output logic rnd_bit,
    output logic lockup
);
    localparam int OUT_IDX = WIDTH - 1;

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;
    logic             fb;
    logic             state_zero;
    logic             lockup_q;
    prbs_act_e        act;

    prbs_feedback #(.WIDTH(WIDTH), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_fb (
        .state (state_q),
        .fb    (fb)
    );

    prbs_zero_detect #(.WIDTH(WIDTH), .CHUNK(ZERO_CHNK)) u_zero (
        .state   (state_q),
        .is_zero (state_zero)
    );

    prbs_priority u_pri (
        .force_dbg  (force_dbg),
        .seed_load  (seed_load),
        .enable     (enable),
        .state_zero (state_zero),
        .act        (act)
    );

    // Next-state selection for the chosen action.
    always_comb begin
        unique case (act)
            ACT_FORCE:   state_d = DBG_STATE;
            ACT_RECOVER: state_d = DBG_STATE;
            ACT_SEED:    state_d = {state_q[WIDTH-2:0], seed_bit};
            ACT_STEP:    state_d = {state_q[WIDTH-2:0], fb};
            default:     state_d = state_q;
        endcase
    end

    // Register update with synchronous reset to the debug state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DBG_STATE;
        else        state_q <= state_d;
    end

    // One-cycle flag marking a recovery from the all-zero state.
    always_ff @(posedge clk) begin
        if (!rst_n) lockup_q <= 1'b0;
        else        lockup_q <= (act == ACT_RECOVER);
    end

    // Output taken from the last stage.
    always_comb rnd_bit = state_q[OUT_IDX];
    always_comb lockup  = lockup_q;
endmodule

// File: rtl/prbs_serial_lfsr_chk.sv
// Checker: temporal properties of the PRBS generator, bound to the top.
// Assumes: the same parameter values as the bound instance.
module prbs_serial_lfsr_chk #(
    parameter int               WIDTH     = 129,
    parameter int               TAP_HI    = 129,
    parameter int               TAP_LO    = 124,
    parameter logic [WIDTH-1:0] DBG_STATE = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             seed_load,
    input logic             seed_bit,
    input logic             force_dbg,
    input logic             rnd_bit,
    input logic             lockup,
    input logic [WIDTH-1:0] state_q
);
    assert_force_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        force_dbg |=> (state_q == DBG_STATE) && !lockup);

    assert_seed_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && !force_dbg) |=> (state_q[0] == $past(seed_bit)) &&
            (state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0])));

    assert_step_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !seed_load && !force_dbg && (state_q != '0)) |=>
            (rnd_bit == $past(state_q[WIDTH-2])) &&
            (state_q[0] == $past(state_q[TAP_HI-1] ^ state_q[TAP_LO-1])));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !seed_load && !force_dbg && (state_q != '0)) |=> $stable(state_q));

    assert_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == '0) && !seed_load && !force_dbg) |=> lockup && (state_q == DBG_STATE));

    assert_lockup_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lockup |=> !lockup);
endmodule

bind prbs_serial_lfsr prbs_serial_lfsr_chk #(
    .WIDTH(WIDTH), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .DBG_STATE(DBG_STATE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .seed_load (seed_load),
    .seed_bit  (seed_bit),
    .force_dbg (force_dbg),
    .rnd_bit   (rnd_bit),
    .lockup    (lockup),
    .state_q   (state_q)
);

// File: tb/tb_prbs_serial_lfsr.sv
module tb_prbs_serial_lfsr;
    localparam int               W   = 129;
    localparam logic [W-1:0]     DBG = 129'h1_DEADBEEF_01234567_89ABCDEF_5A5AA5A5;
    localparam int               REP = 48;

    logic clk = 1'b0;
    logic rst_n, enable, seed_load, seed_bit, force_dbg;
    logic rnd_bit, lockup;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [W-1:0] model;
    logic         exp_lock;
    logic [REP-1:0] ref_seq;
    logic [W-1:0]   seed_vec;

    always #10 clk = ~clk;

    prbs_serial_lfsr dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .seed_load(seed_load),
        .seed_bit(seed_bit), .force_dbg(force_dbg), .rnd_bit(rnd_bit), .lockup(lockup)
    );

    function automatic logic [W-1:0] nxt(input logic [W-1:0] s, input logic f,
                                         input logic sl, input logic b, input logic e);
        if (f)        return DBG;
        if (sl)       return {s[W-2:0], b};
        if (s == '0)  return DBG;
        if (e)        return {s[W-2:0], s[128] ^ s[123]};
        return s;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic f, input logic sl, input logic b, input logic e,
                       input string tag);
        force_dbg = f; seed_load = sl; seed_bit = b; enable = e;
        exp_lock = !f && !sl && (model == '0);
        @(posedge clk);
        model = nxt(model, f, sl, b, e);
        @(negedge clk);
        check(tag, rnd_bit, model[W-1]);
        check("R7 lockup", lockup, exp_lock);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int r;
        r = $urandom(32'hC0FFEE);
        force_dbg = 0; seed_load = 0; seed_bit = 0; enable = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        model = DBG;
        // R1: reset state visible at the ports
        check("R1 rnd_bit", rnd_bit, 1'b1);
        check("R1 lockup", lockup, 1'b0);
        rst_n = 1;

        // R2: long enabled run; record the start for R8
        ref_seq[0] = rnd_bit;
        for (int i = 1; i < REP; i++) begin
            cyc(0, 0, 0, 1, "R2 step");
            ref_seq[i] = rnd_bit;
        end
        for (int i = 0; i < 300; i++) cyc(0, 0, 0, 1, "R2 step");

        // R3: enable toggling
        for (int i = 0; i < 60; i++) cyc(0, 0, 0, 1'(i % 3 == 0), "R3 hold");

        // R5: force beats seed and enable
        cyc(1, 1, 1, 1, "R5 force");
        check("R5 force msb", rnd_bit, DBG[W-1]);

        // R8: the stream after the force repeats the stream after reset
        for (int i = 1; i < REP; i++) begin
            cyc(0, 0, 0, 1, "R8 repeat");
            check("R8 repeat seq", rnd_bit, ref_seq[i]);
        end

        // R4 + R6: random seed of full length with enable toggling, then replay
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < W; i++) begin
                seed_vec[i] = 1'($urandom);
                cyc(0, 1, seed_vec[i], 1'($urandom), "R6 seed over step");
            end
            check("R4 first seed out", rnd_bit, seed_vec[0]);
            for (int i = 1; i < W; i++) begin
                cyc(0, 0, 0, 1, "R4 replay");
                check("R4 seed order", rnd_bit, seed_vec[i]);
            end
        end

        // R7: all-zero seed, released with enable low then high
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < W; i++) cyc(0, 1, 0, 1'(k), "R4 zero seed");
            cyc(0, 0, 0, 1'(k), "R7 recover");
            check("R7 flag", lockup, 1'b1);
            check("R7 msb", rnd_bit, DBG[W-1]);
            cyc(0, 0, 0, 1'(k), "R7 after");
            check("R7 pulse", lockup, 1'b0);
        end

        // Random mix of all controls
        for (int i = 0; i < 4000; i++) begin
            int p;
            p = int'($urandom % 100);
            cyc(1'(p < 2), 1'(p >= 2 && p < 20), 1'($urandom), 1'($urandom % 4 != 0),
                "R2 random mix");
        end

        // Mid-run reset returns to the debug state (R1)
        rst_n = 0;
        @(negedge clk);
        model = DBG;
        check("R1 re-reset", rnd_bit, DBG[W-1]);
        check("R1 re-reset lockup", lockup, 1'b0);
        rst_n = 1;
        finish_run();
    end
endmodule